// File: doc/BRIEF.md
# Serial audio capture and subframe formatter

The block receives PCM audio from a three-wire serial port (bit clock, word select or frame sync, data) and turns each sample into a 32-bit IEC60958-style subframe. The port runs in one of two framings. Two-channel I2S uses word select to name the channel. Multi-channel TDM uses a one-bit frame-sync pulse followed by fixed 32-bit slots. The serial lines are oversampled by the system clock through synchronisers, and all capture happens on detected rising edges of the bit clock.

Each completed sample is left-aligned into a 24-bit audio field. A preamble code is added that marks the start of a 192-frame status block, the first channel or any other channel, together with the channel-status bit for that channel and frame and an even-parity bit. The subframe is offered on a valid/ready stream with its channel index. The block has a single output register. If a new sample arrives while that register is still waiting for ready, the new sample is dropped and a sticky overflow flag is set.

Top module: `aud_fmt_top`

## Requirements
- R1: With `tdm_mode_i`=0 (I2S), the bit sampled on the bit-clock rise where `ws_i` has just changed is not captured. The sample MSB is the next bit. `ws_i` low gives channel 0 and `ws_i` high gives channel 1.
- R2: With `tdm_mode_i`=1, a rise with `ws_i` high marks the frame sync. The next 32 rises form slot 0, the following 32 form slot 1, and so on, and slot k gives channel k. `ch_cnt_i` codes 0/1/2/3 select 2/4/6/8 active channels. Slots at or beyond the active count produce no output.
- R3: `word_len_i` codes 0/1/2/3 select 16/18/20/24 bits, received MSB first. The sample sits in `subframe_o[27:4]` with its MSB at bit 27, and the unused low bits are zero. Bits after the word length inside a slot or half-frame are ignored.
- R4: `subframe_o[1:0]` carries the preamble: 0 for channel 0 of frame 0, 1 for channel 0 of every other frame, 2 for any other channel. `subframe_o[3:2]` and `subframe_o[29:28]` are zero.
- R5: A frame index runs from 0 to 191. It advances once the last active channel of a frame completes (channel 1 in I2S) and wraps from 191 to 0. `subframe_o[30]` equals `cs_bits_i[ch*192 + n]` for channel ch in frame n.
- R6: `subframe_o[31]` makes the count of ones in `subframe_o[31:4]` even.
- R7: While `valid_o` is high and `ready_i` is low, `valid_o`, `chan_o` and `subframe_o` hold.
- R8: A sample that completes while `valid_o` is high and `ready_i` is low is discarded, and `overflow_o` goes high and stays high until reset.
- R9: Reset clears `valid_o` and `overflow_o` and sets the frame index to 0.
- R10: With the output register empty, `valid_o` is high after the fourth `clk_i` rising edge that follows the bit-clock rise carrying a sample's last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial port |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Word select (I2S) or frame sync (TDM) |
| sd_i | input | 1 | Serial data |
| tdm_mode_i | input | 1 | 0 = I2S, 1 = TDM |
| ch_cnt_i | input | 2 | TDM active channel code (2/4/6/8) |
| word_len_i | input | 2 | Word length code (16/18/20/24) |
| cs_bits_i | input | 1536 | Channel-status vectors, 192 bits per channel |
| ready_i | input | 1 | Downstream ready |
| valid_o | output | 1 | Subframe valid |
| chan_o | output | 3 | Channel index of the subframe |
| subframe_o | output | 32 | Formatted subframe |
| overflow_o | output | 1 | Sticky sample-drop flag |

## Verification
A subframe appears four system-clock edges after the bit-clock rise that carries its last bit. A dedicated test measures that delay edge by edge and samples `valid_o` between edges. The other tests record accepted subframes at falling clock edges and compare them only after a drain of several bit periods. The frame-index effects of R5 show up only in the subframes of the next frame, so the long test sends 193 frames and checks the wrap back to the block-start preamble. The overflow flag and the held output of R7 are read one or more cycles after the dropped sample's last bit, before ready is raised.

// File: rtl/aud_fmt_pkg.sv
package aud_fmt_pkg;
  typedef enum logic [1:0] {
    PRE_BLOCK = 2'd0,
    PRE_FIRST = 2'd1,
    PRE_OTHER = 2'd2
  } pre_e;

  function automatic logic [4:0] word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd16;
      2'd1:    return 5'd18;
      2'd2:    return 5'd20;
      default: return 5'd24;
    endcase
  endfunction

  function automatic logic [3:0] tdm_chans(input logic [1:0] code);
    return {1'b0, code, 1'b0} + 4'd2;
  endfunction
endpackage

// File: rtl/aud_deser.sv
module aud_deser
  import aud_fmt_pkg::*;
#(
  parameter int MAX_CH = 8,
  parameter int SLOT_W = 32,
  parameter int AUD_W  = 24
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sck_i,
  input  logic                      ws_i,
  input  logic                      sd_i,
  input  logic                      tdm_mode_i,
  input  logic [1:0]                ch_cnt_i,
  input  logic [1:0]                word_len_i,
  output logic                      smp_v_o,
  output logic [$clog2(MAX_CH)-1:0] smp_ch_o,
  output logic [AUD_W-1:0]          smp_data_o,
  output logic                      frm_end_o
);
  localparam int CH_W  = $clog2(MAX_CH);
  localparam int SW    = CH_W + 1;
  localparam int POS_W = $clog2(SLOT_W);

  logic [2:0]       sck_q;
  logic [1:0]       ws_q, sd_q;
  logic             ws_prev_q, armed_q;
  logic [POS_W-1:0] pos_q, wl_v;
  logic [SW-1:0]    slot_q, nch;
  logic [AUD_W-1:0] shreg_q, shift_in, lsb_mask;
  logic             sck_rise, start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= '0;
      ws_q  <= '0;
      sd_q  <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck_i};
      ws_q  <= {ws_q[0], ws_i};
      sd_q  <= {sd_q[0], sd_i};
    end
  end

  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign start    = tdm_mode_i ? ws_q[1] : (ws_q[1] != ws_prev_q);
  assign wl_v     = POS_W'(word_bits(word_len_i));
  assign nch      = tdm_mode_i ? SW'(tdm_chans(ch_cnt_i)) : SW'(2);
  assign shift_in = {shreg_q[AUD_W-2:0], sd_q[1]};
  assign lsb_mask = (AUD_W'(1) << (AUD_W - int'(wl_v))) - AUD_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_prev_q  <= 1'b0;
      armed_q    <= 1'b0;
      pos_q      <= '0;
      slot_q     <= '0;
      shreg_q    <= '0;
      smp_v_o    <= 1'b0;
      smp_ch_o   <= '0;
      smp_data_o <= '0;
      frm_end_o  <= 1'b0;
    end else begin
      smp_v_o <= 1'b0;
      if (sck_rise) begin
        ws_prev_q <= ws_q[1];
        if (start) begin
          armed_q <= 1'b1;
          pos_q   <= '0;
          slot_q  <= tdm_mode_i ? '0 : SW'(ws_q[1]);
        end else if (armed_q) begin
          if (pos_q < wl_v) shreg_q <= shift_in;
          if (pos_q == wl_v - POS_W'(1) && slot_q < nch) begin
            smp_v_o    <= 1'b1;
            smp_ch_o   <= slot_q[CH_W-1:0];
            smp_data_o <= shift_in << (AUD_W - int'(wl_v));
            frm_end_o  <= (slot_q == nch - SW'(1));
          end
          if (pos_q == POS_W'(SLOT_W - 1)) begin
            // I2S halves hold at the end; TDM steps to the next slot
            if (tdm_mode_i) begin
              pos_q <= '0;
              if (slot_q != SW'(MAX_CH)) slot_q <= slot_q + SW'(1);
            end
          end else begin
            pos_q <= pos_q + POS_W'(1);
          end
        end
      end
    end
  end

  assert_chan_active_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_v_o |-> (SW'(smp_ch_o) < nch));
  assert_low_bits_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_v_o |-> ((smp_data_o & lsb_mask) == '0));
endmodule

// File: rtl/aud_subframe.sv
module aud_subframe
  import aud_fmt_pkg::*;
#(
  parameter int MAX_CH = 8,
  parameter int CS_LEN = 192,
  parameter int AUD_W  = 24
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      smp_v_i,
  input  logic [$clog2(MAX_CH)-1:0] smp_ch_i,
  input  logic [AUD_W-1:0]          smp_data_i,
  input  logic                      frm_end_i,
  input  logic [MAX_CH*CS_LEN-1:0]  cs_bits_i,
  input  logic                      ready_i,
  output logic                      valid_o,
  output logic [$clog2(MAX_CH)-1:0] chan_o,
  output logic [AUD_W+7:0]          subframe_o,
  output logic                      overflow_o
);
  localparam int FRM_W = $clog2(CS_LEN);

  logic [FRM_W-1:0] frm_idx_q;
  logic             cs_bit;
  pre_e             pre;
  logic [AUD_W+2:0] body;

  assign cs_bit = cs_bits_i[int'(smp_ch_i) * CS_LEN + int'(frm_idx_q)];
  assign pre    = (smp_ch_i != '0) ? PRE_OTHER :
                  (frm_idx_q == '0) ? PRE_BLOCK : PRE_FIRST;
  assign body   = {cs_bit, 1'b0, 1'b0, smp_data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_idx_q  <= '0;
      valid_o    <= 1'b0;
      chan_o     <= '0;
      subframe_o <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (smp_v_i && frm_end_i)
        frm_idx_q <= (frm_idx_q == FRM_W'(CS_LEN - 1)) ? '0 : frm_idx_q + FRM_W'(1);
      if (smp_v_i) begin
        if (valid_o && !ready_i) begin
          overflow_o <= 1'b1;
        end else begin
          valid_o    <= 1'b1;
          chan_o     <= smp_ch_i;
          subframe_o <= {^body, body, 2'b00, pre};
        end
      end else if (ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(subframe_o) && $stable(chan_o));
  assert_drop_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && smp_v_i |=> overflow_o);
  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  assert_frame_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_idx_q < FRM_W'(CS_LEN));
  assert_block_ch0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && subframe_o[1:0] == 2'd0 |-> chan_o == '0);
  assert_parity_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(^subframe_o[AUD_W+7:4]));
endmodule

// File: rtl/aud_fmt_top.sv
module aud_fmt_top #(
  parameter int MAX_CH = 8,
  parameter int CS_LEN = 192,
  parameter int SLOT_W = 32,
  parameter int AUD_W  = 24
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sck_i,
  input  logic                      ws_i,
  input  logic                      sd_i,
  input  logic                      tdm_mode_i,
  input  logic [1:0]                ch_cnt_i,
  input  logic [1:0]                word_len_i,
  input  logic [MAX_CH*CS_LEN-1:0]  cs_bits_i,
  input  logic                      ready_i,
  output logic                      valid_o,
  output logic [$clog2(MAX_CH)-1:0] chan_o,
  output logic [AUD_W+7:0]          subframe_o,
  output logic                      overflow_o
);
  localparam int CH_W = $clog2(MAX_CH);

  logic             smp_v, frm_end;
  logic [CH_W-1:0]  smp_ch;
  logic [AUD_W-1:0] smp_data;

  aud_deser #(.MAX_CH(MAX_CH), .SLOT_W(SLOT_W), .AUD_W(AUD_W)) u_deser (
    .clk_i, .rst_ni, .sck_i, .ws_i, .sd_i, .tdm_mode_i, .ch_cnt_i, .word_len_i,
    .smp_v_o(smp_v), .smp_ch_o(smp_ch), .smp_data_o(smp_data), .frm_end_o(frm_end)
  );

  aud_subframe #(.MAX_CH(MAX_CH), .CS_LEN(CS_LEN), .AUD_W(AUD_W)) u_subframe (
    .clk_i, .rst_ni,
    .smp_v_i(smp_v), .smp_ch_i(smp_ch), .smp_data_i(smp_data), .frm_end_i(frm_end),
    .cs_bits_i, .ready_i, .valid_o, .chan_o, .subframe_o, .overflow_o
  );
endmodule

// File: tb/aud_fmt_top_test.sv
`timescale 1ns/1ps
module aud_fmt_top_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic tdm = 1'b0, ready = 1'b1;
  logic [1:0] chc = 2'd0, wlc = 2'd0;
  logic [1535:0] cs_v;
  logic valid_o, overflow_o;
  logic [2:0] chan_o;
  logic [31:0] subframe_o;

  int n_chk = 0, n_bad = 0, rec_n = 0;
  bit done = 1'b0;
  logic [31:0] rec_sf [512];
  logic [2:0]  rec_ch [512];
  logic [23:0] tdm_v [8];

  always #4 clk_i = ~clk_i;

  aud_fmt_top uut (
    .clk_i, .rst_ni, .sck_i(sck), .ws_i(ws), .sd_i(sd), .tdm_mode_i(tdm),
    .ch_cnt_i(chc), .word_len_i(wlc), .cs_bits_i(cs_v), .ready_i(ready),
    .valid_o, .chan_o, .subframe_o, .overflow_o
  );

  always @(negedge clk_i)
    if (rst_ni && valid_o && ready && rec_n < 512) begin
      rec_sf[rec_n] = subframe_o;
      rec_ch[rec_n] = chan_o;
      rec_n++;
    end

  function automatic bit cs_pat(int c, int n);
    return ((n * 5 + c * 3) % 7) < 3;
  endfunction

  function automatic int wl_of(logic [1:0] c);
    return (c == 0) ? 16 : (c == 1) ? 18 : (c == 2) ? 20 : 24;
  endfunction

  function automatic logic [23:0] align(logic [23:0] v, int wl);
    return v & ~((24'd1 << (24 - wl)) - 24'd1);
  endfunction

  function automatic logic [31:0] mk_sf(logic [23:0] d, int c, int n);
    logic [26:0] body;
    logic [1:0] pre;
    pre  = (c != 0) ? 2'd2 : (n == 0) ? 2'd0 : 2'd1;
    body = {cs_pat(c, n), 2'b00, d};
    return {^body, body, 2'b00, pre};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_rx(input int j, input int c, input logic [23:0] d, input int n, input string req);
    chk(j < rec_n, {req, " count"}, 32'(rec_n), 32'(j + 1));
    if (j < rec_n) begin
      chk(rec_ch[j] == 3'(c), {req, " chan"}, 32'(rec_ch[j]), 32'(c));
      chk(rec_sf[j] == mk_sf(d, c, n), {req, " subframe"}, rec_sf[j], mk_sf(d, c, n));
    end
  endtask

  task automatic do_reset();
    @(posedge clk_i); #1;
    rst_ni = 1'b0; sck = 1'b0; ws = 1'b0; sd = 1'b0; ready = 1'b1;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    rec_n = 0;
  endtask

  task automatic bit_out(input logic w, input logic d);
    @(posedge clk_i); #1;
    sck = 1'b0; ws = w; sd = d;
    repeat (2) @(posedge clk_i);
    #1 sck = 1'b1;
    @(posedge clk_i);
  endtask

  task automatic drain();
    repeat (12) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic send_half(input logic w, input logic [23:0] v, input int half);
    bit_out(w, 1'b0);
    for (int i = 1; i < half; i++) bit_out(w, (i <= 24) ? v[24 - i] : 1'b0);
  endtask

  task automatic send_tdm(input int slots);
    for (int b = 0; b < 32 * slots; b++) begin
      int s = b / 32, k = b % 32;
      bit_out(b == 32 * slots - 1, (k < 24) ? tdm_v[s][23 - k] : 1'b0);
    end
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R9 valid after reset", 32'(valid_o), 0);
    chk(overflow_o == 1'b0, "R9 overflow after reset", 32'(overflow_o), 0);
  endtask

  task automatic t_i2s();
    logic [23:0] l [3] = '{24'hA5C3F1, 24'h123456, 24'hFFFFFF};
    logic [23:0] r [3] = '{24'h5A3C0E, 24'h800001, 24'h000100};
    do_reset();
    tdm = 1'b0; wlc = 2'd0;
    bit_out(1'b1, 1'b0);
    for (int f = 0; f < 3; f++) begin
      send_half(1'b0, l[f], 18);
      send_half(1'b1, r[f], 18);
    end
    drain();
    chk(rec_n == 6, "R1 i2s count", 32'(rec_n), 6);
    for (int f = 0; f < 3; f++) begin
      chk_rx(2 * f, 0, align(l[f], 16), f, "R1 R9 i2s left");
      chk_rx(2 * f + 1, 1, align(r[f], 16), f, "R1 R4 i2s right");
    end
  endtask

  task automatic t_wordlen();
    logic [23:0] v = 24'hB7E15F;
    for (int c = 1; c < 4; c++) begin
      do_reset();
      tdm = 1'b0; wlc = 2'(c);
      bit_out(1'b1, 1'b0);
      send_half(1'b0, v, 26);
      send_half(1'b1, ~v, 26);
      drain();
      chk_rx(0, 0, align(v, wl_of(2'(c))), 0, "R3 word length left");
      chk_rx(1, 1, align(~v, wl_of(2'(c))), 0, "R3 R6 word length right");
    end
  endtask

  task automatic t_tdm(input logic [1:0] code, input int slots, input int frames);
    int nact = 2 * (int'(code) + 1);
    do_reset();
    tdm = 1'b1; wlc = 2'd3; chc = code;
    bit_out(1'b1, 1'b0);
    for (int f = 0; f < frames; f++) begin
      for (int s = 0; s < 8; s++) tdm_v[s] = 24'(32'h9E3779 * (s + 1) + f * 32'h1111);
      send_tdm(slots);
    end
    drain();
    chk(rec_n == nact * frames, "R2 tdm count", 32'(rec_n), 32'(nact * frames));
    for (int f = 0; f < frames; f++)
      for (int s = 0; s < nact; s++)
        chk_rx(f * nact + s, s, 24'(32'h9E3779 * (s + 1) + f * 32'h1111), f, "R2 R5 tdm slot");
  endtask

  task automatic t_block();
    do_reset();
    tdm = 1'b0; wlc = 2'd0;
    bit_out(1'b1, 1'b0);
    for (int f = 0; f < 193; f++) begin
      send_half(1'b0, 24'(f * 32'h010203), 18);
      send_half(1'b1, 24'(f * 32'h030201), 18);
    end
    drain();
    chk(rec_n == 386, "R5 block count", 32'(rec_n), 386);
    for (int f = 0; f < 193; f++) begin
      chk_rx(2 * f, 0, align(24'(f * 32'h010203), 16), f % 192, "R4 R5 block left");
      chk_rx(2 * f + 1, 1, align(24'(f * 32'h030201), 16), f % 192, "R5 block right");
    end
  endtask

  task automatic t_stall();
    logic [31:0] held;
    do_reset();
    tdm = 1'b0; wlc = 2'd0;
    @(posedge clk_i); #1 ready = 1'b0;
    bit_out(1'b1, 1'b0);
    send_half(1'b0, 24'hC0FFEE, 18);
    drain();
    held = subframe_o;
    chk(valid_o == 1'b1, "R7 valid held", 32'(valid_o), 1);
    chk(overflow_o == 1'b0, "R8 no overflow yet", 32'(overflow_o), 0);
    send_half(1'b1, 24'h123456, 18);
    drain();
    chk(overflow_o == 1'b1, "R8 overflow set", 32'(overflow_o), 1);
    chk(subframe_o == held, "R7 data stable", subframe_o, held);
    chk(subframe_o == mk_sf(align(24'hC0FFEE, 16), 0, 0), "R7 R8 held sample kept", subframe_o,
        mk_sf(align(24'hC0FFEE, 16), 0, 0));
    @(posedge clk_i); #1 ready = 1'b1;
    drain();
    chk(rec_n == 1, "R8 dropped sample absent", 32'(rec_n), 1);
    chk(valid_o == 1'b0, "R7 valid cleared", 32'(valid_o), 0);
    chk(overflow_o == 1'b1, "R8 overflow sticky", 32'(overflow_o), 1);
    do_reset();
    @(negedge clk_i);
    chk(overflow_o == 1'b0, "R9 overflow cleared by reset", 32'(overflow_o), 0);
  endtask

  task automatic t_latency();
    logic [23:0] v = 24'h8F00F1;
    int lat = 0;
    do_reset();
    tdm = 1'b0; wlc = 2'd0;
    bit_out(1'b1, 1'b0);
    bit_out(1'b0, 1'b0);
    for (int i = 1; i < 16; i++) bit_out(1'b0, v[24 - i]);
    @(posedge clk_i); #1;
    sck = 1'b0; sd = v[8];
    repeat (2) @(posedge clk_i);
    #1 sck = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk_i); lat++;
      @(negedge clk_i);
      if (valid_o) break;
    end
    chk(lat == 4, "R10 latency", 32'(lat), 4);
    chk(subframe_o == mk_sf(align(v, 16), 0, 0), "R10 latency data", subframe_o, mk_sf(align(v, 16), 0, 0));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 8; c++)
      for (int n = 0; n < 192; n++) cs_v[c * 192 + n] = cs_pat(c, n);
    t_reset();
    t_i2s();
    t_wordlen();
    t_tdm(2'd1, 4, 2);
    t_tdm(2'd0, 4, 2);
    t_tdm(2'd3, 8, 1);
    t_stall();
    t_latency();
    t_block();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=%0d exp=0", 1);
    finish_run();
  end
endmodule